// File: doc/BRIEF.md
# Oversampled Binary Step Modulator

This block turns a multi-bit signed control word into a train of single-unit step commands, each one either "advance" or "retard", for a phase-interpolator style actuator that can only move by one unit at a time. It is a first-order sigma-delta loop. Each time a new control sample is strobed in, the block runs a fixed burst of 2^k iterations, where k is the oversampling exponent. Over a burst, the mean of the emitted ±1 steps follows the control word scaled down by 2^k.

Iterations are paced by a programmable clock-enable divider running on the system clock. The divider value should be set to the system clock rate divided by the product of the loop sample rate and the oversampling ratio, so that a burst fits inside one control sample period. The integrator and the quantizer keep their values from one burst to the next, so the residual error is never thrown away.

Top module: `sd_step_modulator`

## Requirements
- R1: After reset the block emits no step. The integrator holds 0 and the quantizer holds −1, so the first iteration of a zero control word gives a +1 step.
- R2: Each accepted `sample_stb` starts a burst of exactly 2^`osr_exp` iterations. `osr_exp` is 3 bits wide, so a burst has 1 to 128 iterations. Each iteration produces exactly one `step_valid` pulse.
- R3: The first step of a burst appears `clk_div` cycles after the clock edge that captures the strobe, and each following step appears `clk_div` cycles after the previous one. A `clk_div` of 0 acts as 1.
- R4: `ctrl_word` is a two's-complement value with 16 fractional bits, so one actuator unit is 65536. In each iteration the input term is `ctrl_word` arithmetically shifted right by `osr_exp`, which is floor division. The feedback term is +65536 when the previous decision was +1 and −65536 when it was −1. The integrator update is the input term minus the feedback term.
- R5: The integrator adds each update to its running sum. Its value and the last decision carry over from one burst to the next, and a new strobe does not clear them.
- R6: The decision is +1 (`step_dir`=1) only when the updated sum is strictly greater than zero. A sum of exactly zero, or any negative sum, gives −1 (`step_dir`=0).
- R7: `step_valid` is a single-cycle pulse, and `step_dir` is valid in the same cycle. No step is emitted while no burst is running.
- R8: A strobe that arrives during a burst captures the new word and exponent and starts a full new burst. The iterations left over from the old burst are dropped.
- R9: While the shifted input stays within ±65536, the integrator stays within ±131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | CTRL_W (24) | Signed control word, 16 fractional bits |
| sample_stb | input | 1 | New control sample, captures `ctrl_word` and `osr_exp` |
| osr_exp | input | EXP_W (3) | Oversampling exponent k, 2^k iterations per sample |
| clk_div | input | DIV_W (8) | System clock cycles per iteration (0 acts as 1) |
| step_valid | output | 1 | One-cycle step command strobe |
| step_dir | output | 1 | Step direction: 1 = +1, 0 = −1 |

## Verification
The integrator bound assertion assumes that the captured word, after the shift by k, has a magnitude of at most one actuator unit, and the stimulus only uses such words, up to exactly −2^k units. The spacing assertion and the burst-length assertion assume that `clk_div` does not change during a burst and that no strobe lands on the same edge as a burst's final iteration. The bench changes the divider only while the block is idle. Its one mid-burst restart is placed at a cycle well away from any iteration edge.

// File: rtl/sd_step_modulator.sv
module sd_step_modulator #(
  parameter int CTRL_W = 24,
  parameter int FRAC   = 16,
  parameter int EXP_W  = 3,
  parameter int DIV_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [CTRL_W-1:0] ctrl_word,
  input  logic                     sample_stb,
  input  logic        [EXP_W-1:0]  osr_exp,
  input  logic        [DIV_W-1:0]  clk_div,
  output logic                     step_valid,
  output logic                     step_dir
);
  localparam int ACC_W   = CTRL_W + 2;
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int LEFT_W  = MAX_EXP + 2;
  localparam logic signed [ACC_W-1:0] UNIT = {{(ACC_W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
  localparam logic [LEFT_W-1:0] ONE_L = {{(LEFT_W-1){1'b0}}, 1'b1};

  logic signed [CTRL_W-1:0] word_q;
  logic        [EXP_W-1:0]  osr_q;
  logic        [LEFT_W-1:0] left;
  logic        [DIV_W-1:0]  div_cnt;
  logic signed [ACC_W-1:0]  sum;
  logic                     q_pos;

  wire                     busy     = |left;
  wire        [DIV_W-1:0]  div_last = (clk_div == '0) ? '0 : clk_div - 1'b1;
  wire                     fire     = busy && !sample_stb && (div_cnt >= div_last);
  wire signed [ACC_W-1:0]  word_ext = {{2{word_q[CTRL_W-1]}}, word_q};
  wire signed [ACC_W-1:0]  shifted  = word_ext >>> osr_q;
  wire signed [ACC_W-1:0]  fb       = q_pos ? UNIT : -UNIT;
  wire signed [ACC_W-1:0]  sum_nx   = sum + shifted - fb;
  wire                     dec_pos  = sum_nx > 0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q     <= '0;
      osr_q      <= '0;
      left       <= '0;
      div_cnt    <= '0;
      sum        <= '0;
      q_pos      <= 1'b0;
      step_valid <= 1'b0;
      step_dir   <= 1'b0;
    end else begin
      step_valid <= fire;
      if (fire) begin
        sum      <= sum_nx;
        q_pos    <= dec_pos;
        step_dir <= dec_pos;
        left     <= left - 1'b1;
        div_cnt  <= '0;
      end else if (busy) begin
        div_cnt  <= div_cnt + 1'b1;
      end
      if (sample_stb) begin
        word_q  <= ctrl_word;
        osr_q   <= osr_exp;
        left    <= ONE_L << osr_exp;
        div_cnt <= '0;
      end
    end
  end

  logic [LEFT_W-1:0] iter_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          iter_cnt <= '0;
    else if (sample_stb) iter_cnt <= '0;
    else if (fire)       iter_cnt <= iter_cnt + 1'b1;
  end

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !step_valid); // R7

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> iter_cnt == (ONE_L << osr_q)); // R2

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && clk_div > 1) |=> !step_valid); // R3

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sum <= (UNIT <<< 1)) && (sum >= -(UNIT <<< 1))); // R9
endmodule

// File: tb/sd_step_modulator_tb.sv
module sd_step_modulator_tb;
  localparam longint U = 65536;

  logic clk = 0, rst_n = 0, sample_stb = 0;
  logic signed [23:0] ctrl_word = '0;
  logic [2:0] osr_exp = '0;
  logic [7:0] clk_div = 8'd1;
  logic step_valid, step_dir;

  sd_step_modulator u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .sample_stb(sample_stb),
    .osr_exp(osr_exp), .clk_div(clk_div), .step_valid(step_valid), .step_dir(step_dir)
  );

  always #2 clk = ~clk;

  int unsigned total = 0, bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit     obs_dir [512];
  longint obs_cyc [512];
  int     n_obs = 0;
  always @(negedge clk)
    if (rst_n && step_valid) begin
      obs_dir[n_obs] = step_dir;
      obs_cyc[n_obs] = cyc;
      n_obs++;
    end

  bit     exp_dir [512];
  longint exp_cyc [512];
  int     n_exp = 0;
  longint m_sum = 0;
  bit     m_pos = 0;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic model_iter(longint w, int k, longint when);
    longint sh = w >>> k;
    m_sum = m_sum + sh - (m_pos ? U : -U);
    m_pos = (m_sum > 0);
    exp_dir[n_exp] = m_pos;
    exp_cyc[n_exp] = when;
    n_exp++;
  endtask

  task automatic strobe(longint w, int k, int d, output longint c0);
    @(negedge clk);
    ctrl_word = 24'(w); osr_exp = 3'(k); clk_div = 8'(d); sample_stb = 1;
    @(negedge clk);
    sample_stb = 0;
    c0 = cyc;
  endtask

  task automatic compare(string tag);
    int dmis = 0, tmis = 0, fi = -1;
    chk(n_obs == n_exp, {tag, " step count"}, n_obs, n_exp);
    for (int i = 0; i < n_exp && i < n_obs; i++) begin
      if (obs_dir[i] != exp_dir[i]) begin dmis++; if (fi < 0) fi = i; end
      if (obs_cyc[i] != exp_cyc[i]) tmis++;
    end
    chk(dmis == 0, {tag, " directions"}, (fi < 0) ? 0 : obs_dir[fi], (fi < 0) ? 0 : exp_dir[fi]);
    chk(tmis == 0, {tag, " step timing"}, (n_obs > 0) ? obs_cyc[0] : -1, (n_exp > 0) ? exp_cyc[0] : -1);
  endtask

  task automatic run_burst(longint w, int k, int d, string tag);
    longint c0;
    int deff = (d == 0) ? 1 : d;
    int len = 1 << k;
    n_obs = 0; n_exp = 0;
    strobe(w, k, d, c0);
    for (int i = 0; i < len; i++) model_iter(w, k, c0 + longint'(deff) * (i + 1));
    repeat (deff * len + 4) @(negedge clk);
    compare(tag);
    chk(step_valid == 0, {tag, " R7 idle after burst"}, step_valid, 0);
  endtask

  task automatic t_reset();
    n_obs = 0;
    repeat (10) @(negedge clk);
    chk(step_valid == 0, "R1 reset step_valid", step_valid, 0);
    chk(n_obs == 0, "R7 no steps while idle", n_obs, 0);
  endtask

  task automatic t_zero();
    run_burst(0, 2, 3, "R1 R6 R3 zero word");
    chk(obs_dir[0] == 1, "R1 quantizer reset to -1", obs_dir[0], 1);
    chk(obs_dir[1] == 0, "R6 zero sum gives -1", obs_dir[1], 0);
  endtask

  task automatic t_half();    run_burst(4 * U, 3, 1, "R4 R5 half unit");       endtask
  task automatic t_negmax();  run_burst(-(U << 3), 3, 2, "R4 R9 full negative"); endtask
  task automatic t_div0();    run_burst(3 * U, 2, 0, "R3 divider zero");       endtask
  task automatic t_osr0();    run_burst(U / 3, 0, 5, "R2 single iteration");   endtask
  task automatic t_osr7();    run_burst(100 * U, 7, 1, "R2 max oversampling"); endtask
  task automatic t_negodd();  run_burst(-1, 2, 1, "R4 arithmetic shift");      endtask

  task automatic t_carry();
    run_burst(0, 0, 2, "R5 carry first");
    run_burst(0, 0, 2, "R5 carry second");
  endtask

  task automatic t_restart();
    longint ca, cb;
    int guard = 0;
    n_obs = 0; n_exp = 0;
    strobe(2 * U, 3, 4, ca);
    while (n_obs < 3 && guard < 100) begin @(negedge clk); guard++; end
    for (int i = 0; i < 3; i++) model_iter(2 * U, 3, ca + 4 * (i + 1));
    strobe(-U, 1, 4, cb);
    for (int i = 0; i < 2; i++) model_iter(-U, 1, cb + 4 * (i + 1));
    repeat (20) @(negedge clk);
    compare("R8 restart mid burst");
  endtask

  bit done = 0;
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero();
    t_half();
    t_negmax();
    t_div0();
    t_osr0();
    t_osr7();
    t_negodd();
    t_carry();
    t_restart();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule